// File: doc/BRIEF.md
# Two-Bank Interrupt Combiner

This block gathers interrupt events from peripherals into two 32-bit banks of sticky status bits and decides what reaches the processor. Each bank has its own enable word. A bank contributes a request bit only where its status and enable bits are both set. The two banks' contributions are then ORed into one combined request word. Bit 0 of that word drives the active-low fast interrupt line. Bits 1 to 15 drive the active-low normal interrupt line. Higher bits are held and can be read back, but they reach neither line.

Software reaches the block over a simple single-cycle register bus. It can write an enable word, flip chosen enable bits through a toggle register, and read a status word. Reading a status word clears that bank. Both output lines are registered, so they follow any change of status or enable one clock later.

Top module: `irq2_combiner`

## Requirements
- R1: After reset both enable words and both status words are 0, and `fiq_n` and `irq_n` are 1.
- R2: A 1 on any bit of `set_bank0` or `set_bank1` in a cycle sets that status bit at the next edge. The bit stays set until its bank's status is read.
- R3: The combined request is (status0 AND enable0) OR (status1 AND enable1), taken bank by bank. A status bit in one bank is never unmasked by the other bank's enable.
- R4: `fiq_n` is 0 exactly when bit 0 of the combined request is 1.
- R5: `irq_n` is 0 exactly when any of bits 1 to 15 of the combined request is 1. Bits 16 to 31 affect neither output.
- R6: A read at address 4 (bank 0) or 5 (bank 1) returns that bank's status word on `reg_rdata` in the same cycle and clears the bank at the next edge. A set pulse in the same cycle as the clearing read is kept.
- R7: A write at address 0 (bank 0) or 1 (bank 1) replaces that bank's enable word with `reg_wdata`.
- R8: A write at address 2 (bank 0) or 3 (bank 1) XORs `reg_wdata` into that bank's enable word.
- R9: A read at address 0 or 1 returns that bank's current enable word. Reads of addresses 2, 3, 6 and 7 return 0.
- R10: `fiq_n` and `irq_n` change one clock after the edge that changes status or enable. In the cycle right after that edge they still show the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_bank0 | input | 32 | Per-bit set pulses for status bank 0 |
| set_bank1 | input | 32 | Per-bit set pulses for status bank 1 |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid while `reg_rd` is high |
| fiq_n | output | 1 | Fast interrupt request, active low |
| irq_n | output | 1 | Normal interrupt request, active low |

## Verification
Several input patterns are driven, and each tells a different fault apart from correct behaviour.

- A status bit raised with its enable clear shows that masking works.
- A bank-0 status bit paired with only a bank-1 enable exposes a design that mixes the banks before masking.
- Enabled events on bit 0, on bit 5 and on bit 20 separate the fast line, the normal line and the bits that reach neither.
- Back-to-back writes of an enable word and then a toggle word show XOR rather than clear.
- A set pulse landing on the same cycle as a clearing read shows whether new events survive the clear.
- Probing the lines in the first cycle after an enable change pins down the one-cycle output delay.

// File: rtl/irq2_pkg.sv
package irq2_pkg;
   localparam int unsigned NUM_BANKS = 2;
   localparam int unsigned ADDR_W    = 3;
   // register slots: each kind occupies NUM_BANKS consecutive addresses
   localparam int unsigned EN_BASE   = 0;
   localparam int unsigned TGL_BASE  = EN_BASE + NUM_BANKS;
   localparam int unsigned ST_BASE   = TGL_BASE + NUM_BANKS;
endpackage

// File: rtl/irq2_bank.sv
module irq2_bank #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned REQ_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] set_i,
   input  logic              en_wr_i,
   input  logic              en_tgl_i,
   input  logic              st_clr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] status_o,
   output logic [DATA_W-1:0] enable_o,
   output logic [REQ_W-1:0]  req_o
);
   logic [DATA_W-1:0] status_q, enable_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         status_q <= '0;
         enable_q <= '0;
      end else begin
         status_q <= (st_clr_i ? '0 : status_q) | set_i;
         if (en_wr_i)
            enable_q <= wdata_i;
         else if (en_tgl_i)
            enable_q <= enable_q ^ wdata_i;
      end
   end

   assign status_o = status_q;
   assign enable_o = enable_q;
   assign req_o    = status_q[REQ_W-1:0] & enable_q[REQ_W-1:0];
endmodule

// File: rtl/irq2_regif.sv
module irq2_regif
   import irq2_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic              reg_wr_i,
   input  logic              reg_rd_i,
   input  logic [ADDR_W-1:0] reg_addr_i,
   input  logic [DATA_W-1:0] status_i [NUM_BANKS],
   input  logic [DATA_W-1:0] enable_i [NUM_BANKS],
   output logic              en_wr_o  [NUM_BANKS],
   output logic              en_tgl_o [NUM_BANKS],
   output logic              st_clr_o [NUM_BANKS],
   output logic [DATA_W-1:0] rdata_o
);
   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_dec
      assign en_wr_o[b]  = reg_wr_i && (reg_addr_i == ADDR_W'(EN_BASE + b));
      assign en_tgl_o[b] = reg_wr_i && (reg_addr_i == ADDR_W'(TGL_BASE + b));
      assign st_clr_o[b] = reg_rd_i && (reg_addr_i == ADDR_W'(ST_BASE + b));
   end

   always_comb begin
      rdata_o = '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (reg_addr_i == ADDR_W'(EN_BASE + b)) rdata_o = enable_i[b];
         if (reg_addr_i == ADDR_W'(ST_BASE + b)) rdata_o = status_i[b];
      end
   end
endmodule

// File: rtl/irq2_outstage.sv
module irq2_outstage #(
   parameter int unsigned REQ_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [REQ_W-1:0] req_i,
   output logic             fiq_n_o,
   output logic             irq_n_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fiq_n_o <= 1'b1;
         irq_n_o <= 1'b1;
      end else begin
         fiq_n_o <= ~req_i[0];
         irq_n_o <= ~(|req_i[REQ_W-1:1]);
      end
   end
endmodule

// File: rtl/irq2_combiner.sv
module irq2_combiner
   import irq2_pkg::*;
#(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned IRQ_TOP = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] set_bank0,
   input  logic [DATA_W-1:0] set_bank1,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              fiq_n,
   output logic              irq_n
);
   localparam int unsigned REQ_W = IRQ_TOP + 1;

   if (IRQ_TOP < 1 || IRQ_TOP >= DATA_W) begin : g_bad_top
      $error("irq2_combiner: IRQ_TOP must lie in 1..DATA_W-1");
   end
   if (NUM_BANKS != 2) begin : g_bad_banks
      $error("irq2_combiner: port list assumes exactly two banks");
   end

   logic [DATA_W-1:0] set_vec     [NUM_BANKS];
   logic [DATA_W-1:0] bank_status [NUM_BANKS];
   logic [DATA_W-1:0] bank_enable [NUM_BANKS];
   logic [REQ_W-1:0]  bank_req    [NUM_BANKS];
   logic              en_wr       [NUM_BANKS];
   logic              en_tgl      [NUM_BANKS];
   logic              st_clr      [NUM_BANKS];
   logic [REQ_W-1:0]  req_comb;

   assign set_vec[0] = set_bank0;
   assign set_vec[1] = set_bank1;

   irq2_regif #(.DATA_W(DATA_W)) regif_i (
      .reg_wr_i   (reg_wr),
      .reg_rd_i   (reg_rd),
      .reg_addr_i (reg_addr),
      .status_i   (bank_status),
      .enable_i   (bank_enable),
      .en_wr_o    (en_wr),
      .en_tgl_o   (en_tgl),
      .st_clr_o   (st_clr),
      .rdata_o    (reg_rdata)
   );

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      irq2_bank #(.DATA_W(DATA_W), .REQ_W(REQ_W)) bank_i (
         .clk      (clk),
         .rst_n    (rst_n),
         .set_i    (set_vec[b]),
         .en_wr_i  (en_wr[b]),
         .en_tgl_i (en_tgl[b]),
         .st_clr_i (st_clr[b]),
         .wdata_i  (reg_wdata),
         .status_o (bank_status[b]),
         .enable_o (bank_enable[b]),
         .req_o    (bank_req[b])
      );
   end

   always_comb begin
      req_comb = '0;
      for (int b = 0; b < NUM_BANKS; b++) req_comb |= bank_req[b];
   end

   irq2_outstage #(.REQ_W(REQ_W)) out_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_i   (req_comb),
      .fiq_n_o (fiq_n),
      .irq_n_o (irq_n)
   );
endmodule

// File: rtl/irq2_combiner_chk.sv
module irq2_combiner_chk #(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned IRQ_TOP = 15
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic              reg_rd,
   input logic [2:0]        reg_addr,
   input logic [DATA_W-1:0] reg_wdata,
   input logic [DATA_W-1:0] set_bank0,
   input logic [DATA_W-1:0] set_bank1,
   input logic [DATA_W-1:0] st0,
   input logic [DATA_W-1:0] st1,
   input logic [DATA_W-1:0] en0,
   input logic [DATA_W-1:0] en1,
   input logic              fiq_n,
   input logic              irq_n
);
   logic [DATA_W-1:0] masked;
   assign masked = (st0 & en0) | (st1 & en1);

   // R4
   fiq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (fiq_n == !$past(masked[0])));

   // R5
   irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (irq_n == !$past(|masked[IRQ_TOP:1])));

   // R6
   clear0_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_addr == 3'd4) |=> (st0 == $past(set_bank0)));

   // R6
   clear1_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_addr == 3'd5) |=> (st1 == $past(set_bank1)));

   // R2
   sticky0_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_rd && reg_addr == 3'd4) |=> ((st0 & $past(st0)) == $past(st0)));

   // R7
   en_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == 3'd0) |=> (en0 == $past(reg_wdata)));

   // R8
   en_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == 3'd3) |=> (en1 == $past(en1 ^ reg_wdata)));
endmodule

bind irq2_combiner irq2_combiner_chk #(.DATA_W(DATA_W), .IRQ_TOP(IRQ_TOP)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_wr    (reg_wr),
   .reg_rd    (reg_rd),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .set_bank0 (set_bank0),
   .set_bank1 (set_bank1),
   .st0       (bank_status[0]),
   .st1       (bank_status[1]),
   .en0       (bank_enable[0]),
   .en1       (bank_enable[1]),
   .fiq_n     (fiq_n),
   .irq_n     (irq_n)
);

// File: tb/irq2_combiner_tb.sv
module irq2_combiner_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] set_bank0 = '0, set_bank1 = '0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        fiq_n, irq_n;
   logic        probe = 1'b0;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   typedef struct {
      bit          is_line;
      logic [31:0] exp;
      string       tag;
   } item_t;
   item_t q[$];

   always #4 clk = ~clk;

   irq2_combiner dut_i (
      .clk(clk), .rst_n(rst_n), .set_bank0(set_bank0), .set_bank1(set_bank1),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .fiq_n(fiq_n), .irq_n(irq_n)
   );

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   always @(negedge clk) begin
      #1;
      if (reg_rd || probe) begin
         item_t it;
         logic [31:0] act;
         if (q.size() == 0) begin
            checks++; errors++;
            $display("FAIL scoreboard: sample with no expected item, act=%h exp=none", reg_rdata);
         end else begin
            it = q.pop_front();
            act = it.is_line ? {30'b0, fiq_n, irq_n} : reg_rdata;
            checks++;
            if (act !== it.exp) begin
               errors++;
               $display("FAIL %s: act=%h exp=%h", it.tag, act, it.exp);
            end
         end
      end
   end

   task automatic pulse_set(input int b, input logic [31:0] v);
      @(negedge clk);
      if (b == 0) set_bank0 = v; else set_bank1 = v;
      @(negedge clk);
      set_bank0 = '0; set_bank1 = '0;
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, input logic [31:0] e, input string tag,
                     input int sb = -1, input logic [31:0] sv = '0);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = a;
      if (sb == 0) set_bank0 = sv;
      if (sb == 1) set_bank1 = sv;
      q.push_back('{is_line: 1'b0, exp: e, tag: tag});
      @(negedge clk);
      reg_rd = 1'b0; set_bank0 = '0; set_bank1 = '0;
   endtask

   task automatic lines(input bit f, input bit i, input string tag, input bit now = 1'b0);
      if (!now) @(negedge clk);
      probe = 1'b1;
      q.push_back('{is_line: 1'b1, exp: {30'b0, f, i}, tag: tag});
      @(negedge clk);
      probe = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: act=timeout exp=completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      lines(1, 1, "R1 lines after reset");
      rd(3'd0, 32'h0, "R1 enable0 reset");
      rd(3'd1, 32'h0, "R1 enable1 reset");
      rd(3'd4, 32'h0, "R1 status0 reset");
      rd(3'd5, 32'h0, "R1 status1 reset");
      // R3 masked event, R2 latch, R6 clear
      pulse_set(0, 32'h1);
      lines(1, 1, "R3 masked bit gives no request");
      rd(3'd4, 32'h1, "R2 status latched");
      rd(3'd4, 32'h0, "R6 status cleared by read");
      // R4 fast line, R10 delay
      pulse_set(0, 32'h1);
      wr(3'd0, 32'h1);
      lines(0, 1, "R4 bit0 drives fiq_n");
      wr(3'd0, 32'h0);
      lines(0, 1, "R10 lines lag enable change", 1'b1);
      lines(1, 1, "R10 lines follow next cycle");
      rd(3'd4, 32'h1, "R6 status0 read");
      // R5 normal line via bank1
      wr(3'd1, 32'h20);
      pulse_set(1, 32'h20);
      lines(1, 0, "R5 bit5 drives irq_n");
      rd(3'd5, 32'h20, "R6 status1 read");
      lines(1, 1, "R6 lines release after clear");
      // R3 no cross-bank unmasking
      wr(3'd1, 32'h1);
      pulse_set(0, 32'h1);
      lines(1, 1, "R3 bank1 enable does not unmask bank0");
      rd(3'd5, 32'h0, "R3 bank1 status untouched");
      rd(3'd4, 32'h1, "R3 bank0 status read");
      // R5 upper bits ignored, R9 enable readback
      wr(3'd0, 32'hFFFF_0000);
      pulse_set(0, 32'h0010_0000);
      lines(1, 1, "R5 bit20 reaches neither line");
      rd(3'd0, 32'hFFFF_0000, "R9 enable0 readback");
      rd(3'd4, 32'h0010_0000, "R5 upper status held");
      // R8 toggle, R7 replace
      wr(3'd0, 32'hF0);
      rd(3'd0, 32'hF0, "R7 enable0 replaced");
      wr(3'd2, 32'h30);
      rd(3'd0, 32'hC0, "R8 toggle bank0");
      wr(3'd3, 32'h5);
      rd(3'd1, 32'h4, "R8 toggle bank1");
      rd(3'd2, 32'h0, "R9 toggle address reads 0");
      // R6 set during clearing read is kept
      pulse_set(1, 32'h2);
      rd(3'd5, 32'h2, "R6 read with concurrent set", 1, 32'h8);
      rd(3'd5, 32'h8, "R6 concurrent set kept");
      // R2 accumulation
      pulse_set(0, 32'h1);
      pulse_set(0, 32'h4);
      rd(3'd4, 32'h5, "R2 status accumulates");
      repeat (2) @(negedge clk);
      if (q.size() != 0) begin
         checks++; errors++;
         $display("FAIL scoreboard: act=%0d pending exp=0", q.size());
      end
      finish_run();
   end
endmodule